// File: doc/BRIEF.md
# Serial Audio Silence Detector

This block sits beside the receive path of a slot-based serial audio port and watches the samples as the deserialiser delivers them. Each sample arrives with a valid strobe, and a frame-start marker separates one frame from the next. The block decides whether a frame was silent, which means every sample delivered in it was all zero. It counts how many silent frames have arrived back to back. When that run reaches a programmed length, it raises a sticky status flag.

Software reads the flag as status only and lowers it with a separate write-one clear strobe. An enable bit routes the flag onto an interrupt line. The block works only while the port operates as a receiver. When the port leaves receive mode, the frame and run bookkeeping is discarded, and a flag that is already set is kept.

Top module: `audio_mute_watch`

## Requirements
- R1: After reset `muteFlag` and `muteIrq` are 0, the silent-frame run is empty and no frame is open.
- R2: A frame counts as silent only if every sample with `sampleValid` high during the frame equals zero. One nonzero sample in any slot, including the first or the last slot and a value with only its MSB set, makes the frame non-silent.
- R3: A frame closes at the next `frameStart` after it opened. `muteFlag` is 1 in the cycle after the `frameStart` that closes the Nth silent frame in a row, where N is `muteThresh`. Before that it is 0.
- R4: Closing a non-silent frame empties the run, so a full N further silent frames are needed before detection.
- R5: A `muteThresh` value of 0 behaves as 1, so a single silent frame sets the flag.
- R6: `muteFlag` stays set until `muteClear` is high on a clock edge. It is 0 from the following cycle.
- R7: If `muteClear` and a detection fall on the same edge, the detection wins and `muteFlag` stays 1.
- R8: `muteIrq` is 1 exactly while `muteFlag` is 1 and `muteIrqEn` is 1.
- R9: Once the run reaches N, it holds there. Continued silence raises no new detection after a clear. A non-silent frame followed by N silent frames is needed to set the flag again.
- R10: While `rxEnable` is 0, frame markers and samples are ignored, the run and the open frame are discarded, and `muteFlag` keeps its value. After re-enabling, the first `frameStart` only opens a frame.
- R11: Samples before the first `frameStart` are ignored. A sample that coincides with `frameStart` belongs to the frame that is opening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Port is operating as a receiver |
| sampleValid | input | 1 | A slot sample is present on sampleData |
| sampleData | input | SAMPLE_W | Received slot sample |
| frameStart | input | 1 | First cycle of a new frame |
| muteThresh | input | CNT_W | Number of consecutive silent frames needed (0 means 1) |
| muteIrqEn | input | 1 | Interrupt enable for the silence flag |
| muteClear | input | 1 | Write-one clear strobe for the flag |
| muteFlag | output | 1 | Sticky silence-detected status |
| muteIrq | output | 1 | Interrupt request |

## Verification
A frame sequence runs with a threshold of three. It mixes all-zero frames with frames that carry a single nonzero sample in the first, a middle or the last slot. This separates a per-frame all-slot judgement from one that looks only at some slots, and it shows whether a broken run is really emptied rather than paused. A clear issued during continued silence distinguishes a run that saturates from one that wraps or re-fires. Directed cases cover the zero threshold, a clear that collides with a detection, receive-mode gating, the flag kept across disable, and how samples are assigned when they coincide with a frame marker or come before any frame.

// File: rtl/mute_pkg.sv
package mute_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic openFrame;  // re-arm accumulator, mark frame open
    logic dropAll;    // receiver off: discard run and frame
    logic zeroCnt;    // empty the silent run
    logic bumpCnt;    // extend the silent run by one
  } dpStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic inFrame;     // a frame is currently open
    logic frameSilent; // every sample so far in the open frame was zero
    logic cntBelow;    // run is shorter than the effective threshold
    logic cntReach;    // one more silent frame meets the threshold
  } dpStatus_t;
endpackage

// File: rtl/mute_dp.sv
module mute_dp
  import mute_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [CNT_W-1:0]    muteThresh,
  input  dpStrobe_t           strb,
  output dpStatus_t           stat
);
  localparam int EXT_W = CNT_W + 1;

  logic             inFrame;
  logic             allZero;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] thrEff;
  logic [EXT_W-1:0] runNext;
  logic             sampleZero;

  assign sampleZero = (sampleData == '0);
  assign thrEff     = (muteThresh == '0) ? CNT_W'(1) : muteThresh;
  assign runNext    = {1'b0, runCnt} + EXT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      allZero <= 1'b1;
      runCnt  <= '0;
    end else if (strb.dropAll) begin
      inFrame <= 1'b0;
      allZero <= 1'b1;
      runCnt  <= '0;
    end else begin
      if (strb.openFrame) begin
        inFrame <= 1'b1;
        allZero <= !(sampleValid && !sampleZero);
      end else if (sampleValid && inFrame) begin
        allZero <= allZero && sampleZero;
      end
      if (strb.zeroCnt)      runCnt <= '0;
      else if (strb.bumpCnt) runCnt <= runNext[CNT_W-1:0];
    end
  end

  assign stat.inFrame     = inFrame;
  assign stat.frameSilent = allZero;
  assign stat.cntBelow    = (runCnt < thrEff);
  assign stat.cntReach    = (runNext == {1'b0, thrEff});
endmodule

// File: rtl/mute_ctl.sv
module mute_ctl
  import mute_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      frameStart,
  input  logic      muteClear,
  input  dpStatus_t stat,
  output dpStrobe_t strb,
  output logic      muteFlag
);
  logic closing;
  logic detect;

  assign closing = rxEnable && frameStart && stat.inFrame;

  always_comb begin
    strb           = '0;
    strb.dropAll   = !rxEnable;
    strb.openFrame = rxEnable && frameStart;
    strb.zeroCnt   = closing && !stat.frameSilent;
    strb.bumpCnt   = closing && stat.frameSilent && stat.cntBelow;
  end

  assign detect = strb.bumpCnt && stat.cntReach;

  always_ff @(posedge clk) begin
    if (!rstN)          muteFlag <= 1'b0;
    else if (detect)    muteFlag <= 1'b1;
    else if (muteClear) muteFlag <= 1'b0;
  end
endmodule

// File: rtl/audio_mute_watch.sv
module audio_mute_watch
  import mute_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxEnable,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                frameStart,
  input  logic [CNT_W-1:0]    muteThresh,
  input  logic                muteIrqEn,
  input  logic                muteClear,
  output logic                muteFlag,
  output logic                muteIrq
);
  dpStrobe_t strb;
  dpStatus_t stat;

  mute_dp #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .muteThresh(muteThresh), .strb(strb), .stat(stat)
  );

  mute_ctl ctl_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .frameStart(frameStart),
    .muteClear(muteClear), .stat(stat), .strb(strb), .muteFlag(muteFlag)
  );

  assign muteIrq = muteFlag && muteIrqEn;
endmodule

// File: rtl/mute_watch_chk.sv
module mute_watch_chk (
  input logic clk,
  input logic rstN,
  input logic rxEnable,
  input logic frameStart,
  input logic muteClear,
  input logic muteIrqEn,
  input logic muteFlag,
  input logic muteIrq
);
  // R3
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muteFlag) |-> $past(frameStart));

  // R10
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muteFlag) |-> $past(rxEnable));

  // R6
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(muteFlag) |-> $past(muteClear));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    muteIrq |-> (muteIrqEn && muteFlag));
endmodule

bind audio_mute_watch mute_watch_chk chk_i (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .frameStart(frameStart),
  .muteClear(muteClear), .muteIrqEn(muteIrqEn), .muteFlag(muteFlag), .muteIrq(muteIrq)
);

// File: tb/audio_mute_watch_tb.sv
module audio_mute_watch_tb_top;
  localparam int SAMPLE_W = 24;
  localparam int CNT_W    = 6;
  localparam int SLOTS    = 4;
  localparam int NVEC     = 16;

  // {clr[28], nzSlot[27:25] (0 = silent, k = slot k-1), nzVal[24:1], expFlag[0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 24'h000000, 1'b0},
    {1'b0, 3'd0, 24'h000000, 1'b0},
    {1'b0, 3'd1, 24'h000001, 1'b0},
    {1'b0, 3'd0, 24'h000000, 1'b0},
    {1'b0, 3'd0, 24'h000000, 1'b0},
    {1'b0, 3'd4, 24'h800000, 1'b0},
    {1'b0, 3'd0, 24'h000000, 1'b0},
    {1'b0, 3'd0, 24'h000000, 1'b0},
    {1'b0, 3'd0, 24'h000000, 1'b0},
    {1'b1, 3'd0, 24'h000000, 1'b1},
    {1'b0, 3'd0, 24'h000000, 1'b0},
    {1'b0, 3'd2, 24'h000100, 1'b0},
    {1'b0, 3'd0, 24'h000000, 1'b0},
    {1'b0, 3'd0, 24'h000000, 1'b0},
    {1'b0, 3'd0, 24'h000000, 1'b0},
    {1'b0, 3'd0, 24'h000000, 1'b1}
  };

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                rxEnable = 1'b0;
  logic                sampleValid = 1'b0;
  logic [SAMPLE_W-1:0] sampleData = '0;
  logic                frameStart = 1'b0;
  logic [CNT_W-1:0]    muteThresh = '0;
  logic                muteIrqEn = 1'b0;
  logic                muteClear = 1'b0;
  logic                muteFlag;
  logic                muteIrq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  audio_mute_watch #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .sampleValid(sampleValid),
    .sampleData(sampleData), .frameStart(frameStart), .muteThresh(muteThresh),
    .muteIrqEn(muteIrqEn), .muteClear(muteClear), .muteFlag(muteFlag), .muteIrq(muteIrq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; rxEnable = 1'b1; sampleValid = 1'b0; sampleData = '0;
    frameStart = 1'b0; muteClear = 1'b0; muteIrqEn = 1'b0;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic mark(input logic v, input logic [SAMPLE_W-1:0] d, input logic clr);
    frameStart = 1'b1; sampleValid = v; sampleData = d; muteClear = clr;
    step();
    frameStart = 1'b0; sampleValid = 1'b0; sampleData = '0; muteClear = 1'b0;
  endtask

  task automatic zeroFrame();
    for (int s = 0; s < SLOTS; s++) begin
      sampleValid = 1'b1; sampleData = '0; step();
    end
    sampleValid = 1'b0;
  endtask

  task automatic clearPulse();
    muteClear = 1'b1; step(); muteClear = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // R1: reset state
    chk("R1 flag", muteFlag, 1'b0);
    chk("R1 irq", muteIrq, 1'b0);

    // Table walk: R2, R3, R4, R9 with threshold 3
    muteThresh = 6'd3;
    for (int i = 0; i < NVEC; i++) begin
      mark(1'b0, '0, 1'b0);
      chk("R2/R3/R4/R9 table flag", muteFlag, VEC[i][0]);
      chk("R8 irq disabled", muteIrq, 1'b0);
      for (int s = 0; s < SLOTS; s++) begin
        sampleValid = 1'b1;
        sampleData  = (int'(VEC[i][27:25]) == s + 1) ? VEC[i][24:1] : '0;
        step();
      end
      sampleValid = 1'b0; sampleData = '0;
      step();
      if (VEC[i][28]) begin
        clearPulse();
        chk("R6 cleared", muteFlag, 1'b0);
      end
    end

    // R5: threshold 0 acts as 1
    doReset();
    muteThresh = 6'd0;
    mark(1'b0, '0, 1'b0);
    zeroFrame();
    chk("R5 before close", muteFlag, 1'b0);
    mark(1'b0, '0, 1'b0);
    chk("R5 one frame", muteFlag, 1'b1);

    // R8: interrupt follows flag and enable
    muteIrqEn = 1'b1; #1;
    chk("R8 irq on", muteIrq, 1'b1);
    muteIrqEn = 1'b0; #1;
    chk("R8 irq masked", muteIrq, 1'b0);

    // R7: clear colliding with a detection
    sampleValid = 1'b1; sampleData = 24'h000010; step(); sampleValid = 1'b0;
    mark(1'b0, '0, 1'b0);          // closes non-silent frame
    chk("R7 flag held", muteFlag, 1'b1);
    zeroFrame();
    mark(1'b0, '0, 1'b1);          // detection plus clear
    chk("R7 detect wins", muteFlag, 1'b1);

    // R6: clear alone, held across idle cycles
    clearPulse();
    chk("R6 clear", muteFlag, 1'b0);
    step(); step();
    chk("R6 stays clear", muteFlag, 1'b0);

    // R10: disabled receiver ignores frames; flag kept across disable
    doReset();
    muteThresh = 6'd1;
    rxEnable = 1'b0;
    mark(1'b0, '0, 1'b0); zeroFrame(); mark(1'b0, '0, 1'b0); zeroFrame();
    mark(1'b0, '0, 1'b0);
    chk("R10 ignored while off", muteFlag, 1'b0);
    rxEnable = 1'b1;
    mark(1'b0, '0, 1'b0);
    chk("R10 first marker opens only", muteFlag, 1'b0);
    zeroFrame();
    mark(1'b0, '0, 1'b0);
    chk("R10 detect after enable", muteFlag, 1'b1);
    rxEnable = 1'b0; step(); step();
    chk("R10 flag kept when off", muteFlag, 1'b1);

    // R11: samples before any frame ignored; coincident sample joins new frame
    doReset();
    muteThresh = 6'd1;
    sampleValid = 1'b1; sampleData = 24'h00ffff; step(); sampleValid = 1'b0;
    mark(1'b0, '0, 1'b0);
    zeroFrame();
    mark(1'b1, 24'h000002, 1'b0);  // closes silent frame, opens with nonzero
    chk("R11 pre-frame sample ignored", muteFlag, 1'b1);
    clearPulse();
    zeroFrame();
    mark(1'b0, '0, 1'b0);
    chk("R11 coincident sample counted", muteFlag, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule